// File: doc/BRIEF.md
# Analog Power-Up Delay Sequencer

This block decides when the analog front end of a converter is powered and when a conversion request may be granted. It runs in one of two modes, chosen by a pre-enable bit in a 32-bit configuration word.

In on-demand mode the analog section is off while nothing is happening. Each trigger powers it up, waits a programmed number of delay ticks, grants the conversion, and powers down again when the conversion reports done.

In pre-enable mode the start-up delay runs once, as soon as the bit is seen set, with or without a trigger. Any trigger that arrives during that delay is held back. After the delay the analog section stays powered, and later triggers are granted with no further wait.

The delay counts a prescaled tick input rather than raw clocks. Two other configuration fields, power level and reference choice, are only registered and passed on to the analog macro.

Top module: `pud_seq_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ana_en_o`, `grant_o` and `busy_o` are all 0.
- R2: In on-demand mode (configuration bit 28 = 0) with a delay field D > 0 (bits 23:16), a trigger raises `ana_en_o` and `busy_o` in the next cycle. `grant_o` goes high for exactly one cycle, in the cycle after the clock edge that samples the D-th `tick_i` pulse, and not before.
- R3: In on-demand mode with D = 0, `grant_o` is high in the cycle right after the trigger is sampled.
- R4: In on-demand mode, `conv_done_i` during a conversion drops `ana_en_o` and `busy_o` in the next cycle.
- R5: Setting bit 28 starts the delay with no trigger: `ana_en_o` rises in the next cycle and stays high after D ticks. `busy_o` stays 0 when no trigger is waiting.
- R6: A trigger that arrives during the pre-enable start-up delay produces no grant until that delay has expired. It is then granted in the cycle after the final tick.
- R7: Extra triggers during a delay are not queued: one delay yields exactly one grant, and no further grant follows that conversion's done.
- R8: Once pre-enable start-up is complete, a trigger is granted in the next cycle with no ticks. `ana_en_o` stays high across `conv_done_i`.
- R9: Clearing bit 28 while warmed and idle drops `ana_en_o` in the next cycle. Clearing it during a conversion keeps `ana_en_o` high until `conv_done_i`.
- R10: Triggers during an active conversion are ignored and produce no grant.
- R11: `pwr_lvl_o` carries configuration bits 5:4 and `ref_sel_o` carries bits 7:6, one cycle later. The reserved reference code 3 is output as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 32 | Configuration word: bit 28 pre-enable, 23:16 delay, 7:6 reference, 5:4 power level |
| trig_i | input | 1 | Conversion trigger request |
| tick_i | input | 1 | Prescaled delay tick |
| conv_done_i | input | 1 | Converter reports end of conversion |
| ana_en_o | output | 1 | Analog section enable |
| grant_o | output | 1 | One-cycle conversion start grant |
| busy_o | output | 1 | Trigger waiting or conversion running |
| pwr_lvl_o | output | 2 | Registered power level select |
| ref_sel_o | output | 2 | Registered reference select, reserved code forced to 0 |

## Verification
The hardest case to reach is a trigger held off during the one-shot pre-enable delay. To get there, the bench first writes pre-enable with no trigger, then raises a trigger after the delay has begun, and delivers ticks with idle gaps between them. It checks that the grant appears only after the final tick.

A second hard case is clearing pre-enable in the middle of a conversion, where the analog enable must hold until done. The bench reaches it with a directed step.

Random on-demand rounds vary the delay length, the gaps between ticks, and the extra triggers inserted during each delay.

// File: rtl/pud_pkg.sv
package pud_pkg;
    localparam int CFG_W      = 32;
    localparam int PRE_EN_BIT = 28;
    localparam int DLY_LSB    = 16;
    localparam int PWR_LSB    = 4;
    localparam int REF_LSB    = 6;
    localparam int SEL_W      = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WARM  = 2'd1,
        ST_CONV  = 2'd2,
        ST_READY = 2'd3
    } pud_state_e;
endpackage

// File: rtl/pud_cfg_decode.sv
module pud_cfg_decode
    import pud_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [CFG_W-1:0]   cfg_i,
    output logic               pre_en_o,
    output logic [DLY_W-1:0]   dly_o,
    output logic [SEL_W-1:0]   pwr_lvl_o,
    output logic [SEL_W-1:0]   ref_sel_o
);
    localparam logic [SEL_W-1:0] REF_RSVD = '1;

    typedef struct packed {
        logic [SEL_W-1:0] pwr;
        logic [SEL_W-1:0] rsel;
    } sel_t;

    sel_t sel_d, sel_q;
    logic cfg_unused;

    assign cfg_unused = ^cfg_i;
    assign pre_en_o   = cfg_i[PRE_EN_BIT];
    assign dly_o      = cfg_i[DLY_LSB +: DLY_W];

    always_comb begin
        sel_d.pwr  = cfg_i[PWR_LSB +: SEL_W];
        sel_d.rsel = cfg_i[REF_LSB +: SEL_W];
        if (sel_d.rsel == REF_RSVD) begin
            sel_d.rsel = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign pwr_lvl_o = sel_q.pwr;
    assign ref_sel_o = sel_q.rsel;
endmodule

// File: rtl/pud_delay_counter.sv
module pud_delay_counter #(
    parameter int DLY_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [DLY_W-1:0] load_val_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic             expire_o
);
    localparam logic [DLY_W-1:0] LAST = DLY_W'(1);

    typedef struct packed {
        logic [DLY_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load_i) begin
            c_d.cnt = load_val_i;
        end else if (run_i && tick_i && (c_q.cnt != '0)) begin
            c_d.cnt = c_q.cnt - LAST;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign expire_o = run_i && tick_i && (c_q.cnt == LAST);

    AST_CNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (c_q.cnt != '0)); // R2
endmodule

// File: rtl/pud_ctrl.sv
module pud_ctrl
    import pud_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pre_en_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             trig_i,
    input  logic             conv_done_i,
    input  logic             expire_i,
    output logic             load_o,
    output logic             run_o,
    output logic             ana_en_o,
    output logic             grant_o,
    output logic             busy_o
);
    typedef struct packed {
        pud_state_e state;
        logic       pending;
        logic       grant;
    } ctl_t;

    ctl_t s_d, s_q;
    logic no_delay;

    assign no_delay = (dly_i == '0);

    always_comb begin
        s_d       = s_q;
        s_d.grant = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (pre_en_i || trig_i) begin
                    if (no_delay) begin
                        s_d.state = trig_i ? ST_CONV : ST_READY;
                        s_d.grant = trig_i;
                    end else begin
                        s_d.state   = ST_WARM;
                        s_d.pending = trig_i;
                    end
                end
            end
            ST_WARM: begin
                if (expire_i) begin
                    s_d.pending = 1'b0;
                    if (s_q.pending || trig_i) begin
                        s_d.state = ST_CONV;
                        s_d.grant = 1'b1;
                    end else begin
                        s_d.state = pre_en_i ? ST_READY : ST_IDLE;
                    end
                end else if (trig_i) begin
                    s_d.pending = 1'b1;
                end else if (!pre_en_i && !s_q.pending) begin
                    s_d.state = ST_IDLE;
                end
            end
            ST_CONV: begin
                if (conv_done_i) begin
                    s_d.state = pre_en_i ? ST_READY : ST_IDLE;
                end
            end
            ST_READY: begin
                if (trig_i) begin
                    s_d.state = ST_CONV;
                    s_d.grant = 1'b1;
                end else if (!pre_en_i) begin
                    s_d.state = ST_IDLE;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{state: ST_IDLE, pending: 1'b0, grant: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign load_o   = (s_q.state != ST_WARM) && (s_d.state == ST_WARM);
    assign run_o    = (s_q.state == ST_WARM);
    assign ana_en_o = (s_q.state != ST_IDLE);
    assign grant_o  = s_q.grant;
    assign busy_o   = (s_q.state == ST_CONV) || s_q.pending;

    AST_GRANT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_o |=> !grant_o); // R2

    AST_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_o && !expire_i) |=> !grant_o); // R6

    AST_ANA_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ana_en_o) |-> ($past(!pre_en_i) || $past(s_q.state == ST_CONV && conv_done_i))); // R9

    AST_GRANT_POWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_o |-> ana_en_o); // R8
endmodule

// File: rtl/pud_seq_top.sv
module pud_seq_top
    import pud_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [31:0]      cfg_i,
    input  logic             trig_i,
    input  logic             tick_i,
    input  logic             conv_done_i,
    output logic             ana_en_o,
    output logic             grant_o,
    output logic             busy_o,
    output logic [1:0]       pwr_lvl_o,
    output logic [1:0]       ref_sel_o
);
    logic             pre_en;
    logic [DLY_W-1:0] dly;
    logic             load, run, expire;

    pud_cfg_decode #(.DLY_W(DLY_W)) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cfg_i     (cfg_i),
        .pre_en_o  (pre_en),
        .dly_o     (dly),
        .pwr_lvl_o (pwr_lvl_o),
        .ref_sel_o (ref_sel_o)
    );

    pud_delay_counter #(.DLY_W(DLY_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .load_val_i (dly),
        .run_i      (run),
        .tick_i     (tick_i),
        .expire_o   (expire)
    );

    pud_ctrl #(.DLY_W(DLY_W)) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pre_en_i    (pre_en),
        .dly_i       (dly),
        .trig_i      (trig_i),
        .conv_done_i (conv_done_i),
        .expire_i    (expire),
        .load_o      (load),
        .run_o       (run),
        .ana_en_o    (ana_en_o),
        .grant_o     (grant_o),
        .busy_o      (busy_o)
    );
endmodule

// File: tb/sim_pud_seq_top.sv
`timescale 1ns/1ps
module sim_pud_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg = 32'h0080_0000;
    logic        trig = 1'b0, tick = 1'b0, done = 1'b0;
    logic        ana, grant, busy;
    logic [1:0]  pwr, rsel;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pud_seq_top u0 (
        .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .trig_i(trig), .tick_i(tick),
        .conv_done_i(done), .ana_en_o(ana), .grant_o(grant), .busy_o(busy),
        .pwr_lvl_o(pwr), .ref_sel_o(rsel)
    );

    function automatic logic [31:0] mk_cfg(bit pre, int dly, int pw, int rf);
        logic [31:0] w = '0;
        w[28]    = pre;
        w[23:16] = 8'(dly);
        w[5:4]   = 2'(pw);
        w[7:6]   = 2'(rf);
        return w;
    endfunction

    function automatic int exp_ref(int rf);
        return (rf == 3) ? 0 : rf;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic pulse_trig();
        trig = 1'b1; step(); trig = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1; step(); tick = 1'b0;
    endtask

    task automatic pulse_done();
        done = 1'b1; step(); done = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 ana in reset", ana, 0);
        chk("R1 grant in reset", grant, 0);
        chk("R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        step();
        chk("R1 ana after reset", ana, 0);
        chk("R1 busy after reset", busy, 0);

        // R11 pass-through of power level and reference select
        for (int r = 0; r < 4; r++) begin
            cfg = mk_cfg(0, 0, 3 - r, r);
            step();
            chk("R11 pwr", pwr, 3 - r);
            chk("R11 ref", rsel, exp_ref(r));
        end
        chk("R11 idle ana", ana, 0);

        // R3 zero delay on-demand
        cfg = mk_cfg(0, 0, 0, 0);
        pulse_trig();
        chk("R3 grant", grant, 1);
        chk("R3 ana", ana, 1);
        step();
        chk("R2 grant one cycle", grant, 0);
        // R10 triggers during conversion ignored
        pulse_trig();
        chk("R10 no grant", grant, 0);
        step();
        chk("R10 no grant later", grant, 0);
        pulse_done();
        chk("R4 ana off", ana, 0);
        chk("R4 busy off", busy, 0);

        // R2 / R7 directed delay of 3 with extra triggers in gaps
        cfg = mk_cfg(0, 3, 0, 0);
        pulse_trig();
        chk("R2 ana up", ana, 1);
        chk("R2 busy", busy, 1);
        for (int k = 1; k <= 3; k++) begin
            pulse_trig();
            chk("R7 no early grant", grant, 0);
            pulse_tick();
            chk("R2 grant after last tick", grant, (k == 3) ? 1 : 0);
        end
        step();
        chk("R2 grant pulse", grant, 0);
        pulse_done();
        chk("R4 ana off", ana, 0);
        repeat (3) begin
            pulse_tick();
            chk("R7 no queued grant", grant, 0);
        end

        // R5 pre-enable delay without trigger
        cfg = mk_cfg(1, 2, 0, 0);
        step();
        chk("R5 ana up", ana, 1);
        chk("R5 busy idle", busy, 0);
        pulse_tick();
        pulse_tick();
        chk("R5 no grant", grant, 0);
        repeat (3) step();
        chk("R5 stays on", ana, 1);

        // R9 clear while warmed and idle
        cfg = mk_cfg(0, 2, 0, 0);
        step();
        chk("R9 ana drop", ana, 0);

        // R6 trigger held during initial delay
        cfg = mk_cfg(1, 4, 0, 0);
        step();
        step();
        pulse_trig();
        chk("R6 busy pending", busy, 1);
        for (int k = 1; k <= 4; k++) begin
            step();
            chk("R6 held off", grant, 0);
            pulse_tick();
            chk("R6 grant at expiry", grant, (k == 4) ? 1 : 0);
        end
        pulse_done();
        chk("R8 ana held", ana, 1);

        // R8 warmed: immediate grant
        pulse_trig();
        chk("R8 immediate grant", grant, 1);
        pulse_done();
        chk("R8 ana held after done", ana, 1);

        // R9 clear during conversion
        pulse_trig();
        chk("R8 grant", grant, 1);
        cfg = mk_cfg(0, 4, 0, 0);
        repeat (3) begin
            step();
            chk("R9 ana held in conv", ana, 1);
        end
        pulse_done();
        chk("R9 ana drop at done", ana, 0);

        // Random on-demand rounds
        for (int it = 0; it < 25; it++) begin
            int n = 1 + int'($urandom % 5);
            cfg = mk_cfg(0, n, int'($urandom % 4), 0);
            pulse_trig();
            chk("R2 busy rnd", busy, 1);
            for (int k = 1; k <= n; k++) begin
                int gap = int'($urandom % 3);
                for (int g = 0; g < gap; g++) begin
                    trig = 1'($urandom % 2);
                    step();
                    trig = 1'b0;
                    chk("R7 no grant in gap", grant, 0);
                end
                pulse_tick();
                chk("R2 grant rnd", grant, (k == n) ? 1 : 0);
            end
            step();
            chk("R2 pulse rnd", grant, 0);
            repeat (int'($urandom % 3)) step();
            chk("R4 ana before done", ana, 1);
            pulse_done();
            chk("R4 ana after done", ana, 0);
            chk("R4 busy after done", busy, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule